// File: doc/BRIEF.md
# Ping-Pong Slice Buffer for LED Driver Bit-Plane Streaming

This block keeps two banks, each holding one full display slice of pixels, and streams one bank to a row of LED driver controllers while the other bank loads the next slice from an external pixel memory. A fill begins when the angle sensor reports a new position. The fill reads the memory one pixel per cycle with a fixed read latency of one cycle.

The drain side does not send pixels one after another. On each step it gives every driver one bit at the same moment. That bit is the bit of one weight for one LED of that driver. The drain walks the LEDs of a plane, then the planes from the most significant bit down, then the multiplex rows. The controller gates each step with an advance enable. During blanking and pause cycles the data pointer stays where it is, so the bit stream stays aligned to the LEDs.

When a drain ends and a loaded slice is waiting, the banks swap with no idle cycle. A one-cycle new-slice pulse marks the first bit of the new bank. If no loaded slice is waiting when the drain ends, the output goes idle and an overrun flag is raised. The swap then happens as soon as the late fill completes.

Top module: `slice_pingpong_buf`

## Requirements
- R1: While reset is low and in the first cycle after it is released, drvValid, newSlice, overrun and ramRd are all 0.
- R2: A fill starts when posStrobe is seen while no fill is running, no write is pending and no loaded slice is waiting. The fill then drives ramRd high for NUM_DRV*MUX*LEDS consecutive cycles, with ramAddr counting up from 0 by one each cycle. ramData is taken one cycle after each address.
- R3: A posStrobe that arrives while a fill is running, or while a loaded slice is waiting for a swap, is ignored. It does not restart or disturb the fill, and it does not start a new one.
- R4: Memory address p holds the pixel for driver d, row r and LED l, where p = (d*MUX + r)*LEDS + l.
- R5: While drvValid is high, drvBits[d] is bit PIX_W-1-k of the pixel for (d, muxRow, l). Here k is the plane index, running from 0 to PLANES-1. The drain visits LED l = 0..LEDS-1 within each plane, then the planes, then rows 0..MUX-1, and muxRow shows the current row.
- R6: The read position moves only in cycles where dataEn is high. In a cycle where dataEn is low, drvBits, muxRow and drvValid keep their values.
- R7: A completed fill is presented in the cycle that follows either its completion (when no drain is running) or the final advance of the running drain, whichever is later. There is no idle cycle between slices.
- R8: newSlice is high for exactly one cycle: the first cycle in which a freshly swapped bank is presented, with muxRow at 0.
- R9: If a drain ends with no loaded slice waiting, drvValid drops and overrun goes high. Overrun stays high until the next swap and clears in the same cycle that drvValid returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Driver clock |
| rstN | input | 1 | Active-low synchronous reset |
| posStrobe | input | 1 | New angular position; requests a fill |
| dataEn | input | 1 | Advance enable from the driver controller (low during blanking and pause) |
| ramData | input | PIX_W | Pixel returned one cycle after ramAddr |
| ramRd | output | 1 | Pixel memory read request |
| ramAddr | output | clog2(NUM_DRV*MUX*LEDS) | Pixel memory address |
| drvValid | output | 1 | A bank is being presented |
| drvBits | output | NUM_DRV | One bit per driver for the current position |
| muxRow | output | clog2(MUX) | Current multiplex row |
| newSlice | output | 1 | Pulse on the first bit of a newly swapped bank |
| overrun | output | 1 | A drain ended with no loaded slice waiting |

## Verification
Pixel contents are an arithmetic function of the slice number and the address, so each slice differs from the one before it. A wrong address mapping or a wrong bit order therefore shows up as a value mismatch. This also catches a stale bank being replayed. Drains run both with the advance enable held high and with pause cycles placed among the steps; the pause cases tell a pointer that honours dataEn from one that slips. Fills are started early (overlapping the drain, to test the back-to-back swap), late (after the drain has ended, to test overrun and the recovery swap), and twice more while busy or while a slice is waiting, to show that those extra requests are dropped.

// File: rtl/spb_pkg.sv
package spb_pkg;

  // Width of an index that must count 0..n-1 (at least one bit).
  function automatic int bitsFor(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;    // store ramData this cycle
    logic wrBank;  // bank being filled
    logic rdBank;  // bank being drained
  } spbStrobes_t;

endpackage

// File: rtl/spb_ctrl.sv
module spb_ctrl
  import spb_pkg::*;
#(
  parameter int NUM_DRV = 30,
  parameter int LEDS    = 16,
  parameter int MUX     = 8,
  parameter int PIX_W   = 16,
  parameter int PLANES  = 16,
  localparam int WORDS  = MUX * LEDS,
  localparam int NPIX   = NUM_DRV * WORDS,
  localparam int ADDR_W = bitsFor(NPIX),
  localparam int WORD_W = bitsFor(WORDS),
  localparam int DRV_W  = bitsFor(NUM_DRV),
  localparam int LED_W  = bitsFor(LEDS),
  localparam int ROW_W  = bitsFor(MUX),
  localparam int PLN_W  = bitsFor(PLANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              posStrobe,
  input  logic              dataEn,
  output logic              ramRd,
  output logic [ADDR_W-1:0] ramAddr,
  output spbStrobes_t       ctl,
  output logic [DRV_W-1:0]  wrDrv,
  output logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] rdWord,
  output logic [PLN_W-1:0]  rdPlane,
  output logic              drvValid,
  output logic [ROW_W-1:0]  muxRow,
  output logic              newSlice,
  output logic              overrun
);

  localparam logic [DRV_W-1:0]  DRV_LAST  = DRV_W'(NUM_DRV - 1);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS - 1);
  localparam logic [LED_W-1:0]  LED_LAST  = LED_W'(LEDS - 1);
  localparam logic [PLN_W-1:0]  PLN_LAST  = PLN_W'(PLANES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(MUX - 1);

  // fill side
  logic              fillBusy_q, wrPend_q, fillReady_q;
  logic [DRV_W-1:0]  fDrv_q, wDrv_q;
  logic [WORD_W-1:0] fWord_q, wWord_q;
  // drain side
  logic              drainActive_q, drainBank_q, overrun_q, newSlice_q;
  logic [LED_W-1:0]  led_q;
  logic [PLN_W-1:0]  plane_q;
  logic [ROW_W-1:0]  row_q;

  logic startFill, fillLast, wrLast, step, ledWrap, planeWrap, rowWrap, drainEnd, swap;

  always_comb begin
    startFill = posStrobe && !fillBusy_q && !wrPend_q && !fillReady_q;
    fillLast  = fillBusy_q && (fDrv_q == DRV_LAST) && (fWord_q == WORD_LAST);
    wrLast    = wrPend_q && (wDrv_q == DRV_LAST) && (wWord_q == WORD_LAST);
    step      = drainActive_q && dataEn;
    ledWrap   = (led_q == LED_LAST);
    planeWrap = (plane_q == PLN_LAST);
    rowWrap   = (row_q == ROW_LAST);
    drainEnd  = step && ledWrap && planeWrap && rowWrap;
    swap      = fillReady_q && (!drainActive_q || drainEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillBusy_q    <= 1'b0;
      wrPend_q      <= 1'b0;
      fillReady_q   <= 1'b0;
      fDrv_q        <= '0;
      fWord_q       <= '0;
      wDrv_q        <= '0;
      wWord_q       <= '0;
      drainActive_q <= 1'b0;
      drainBank_q   <= 1'b0;
      overrun_q     <= 1'b0;
      newSlice_q    <= 1'b0;
      led_q         <= '0;
      plane_q       <= '0;
      row_q         <= '0;
    end else begin
      newSlice_q <= swap;

      // fill address walk
      if (startFill) begin
        fillBusy_q <= 1'b1;
        fDrv_q     <= '0;
        fWord_q    <= '0;
      end else if (fillBusy_q) begin
        if (fWord_q == WORD_LAST) begin
          fWord_q <= '0;
          fDrv_q  <= fDrv_q + 1'b1;
        end else begin
          fWord_q <= fWord_q + 1'b1;
        end
        if (fillLast) fillBusy_q <= 1'b0;
      end

      // one-cycle memory latency: write lags the request
      wrPend_q <= fillBusy_q;
      wDrv_q   <= fDrv_q;
      wWord_q  <= fWord_q;

      if (wrLast)    fillReady_q <= 1'b1;
      else if (swap) fillReady_q <= 1'b0;

      // drain walk: LED, then plane, then row
      if (swap) begin
        drainBank_q   <= ~drainBank_q;
        drainActive_q <= 1'b1;
        overrun_q     <= 1'b0;
        led_q         <= '0;
        plane_q       <= '0;
        row_q         <= '0;
      end else if (step) begin
        if (ledWrap) begin
          led_q <= '0;
          if (planeWrap) begin
            plane_q <= '0;
            row_q   <= rowWrap ? '0 : row_q + 1'b1;
          end else begin
            plane_q <= plane_q + 1'b1;
          end
        end else begin
          led_q <= led_q + 1'b1;
        end
        if (drainEnd) begin
          drainActive_q <= 1'b0;
          overrun_q     <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ramRd      = fillBusy_q;
    ramAddr    = ADDR_W'(fDrv_q) * ADDR_W'(WORDS) + ADDR_W'(fWord_q);
    ctl.wrEn   = wrPend_q;
    ctl.wrBank = ~drainBank_q;
    ctl.rdBank = drainBank_q;
    wrDrv      = wDrv_q;
    wrWord     = wWord_q;
    rdWord     = WORD_W'(row_q) * WORD_W'(LEDS) + WORD_W'(led_q);
    rdPlane    = plane_q;
    drvValid   = drainActive_q;
    muxRow     = row_q;
    newSlice   = newSlice_q;
    overrun    = overrun_q;
  end

endmodule

// File: rtl/spb_datapath.sv
module spb_datapath
  import spb_pkg::*;
#(
  parameter int NUM_DRV = 30,
  parameter int LEDS    = 16,
  parameter int MUX     = 8,
  parameter int PIX_W   = 16,
  parameter int PLANES  = 16,
  localparam int WORDS  = MUX * LEDS,
  localparam int WORD_W = bitsFor(WORDS),
  localparam int DRV_W  = bitsFor(NUM_DRV),
  localparam int PLN_W  = bitsFor(PLANES),
  localparam int BIT_W  = bitsFor(PIX_W)
) (
  input  logic               clk,
  input  spbStrobes_t        ctl,
  input  logic [DRV_W-1:0]   wrDrv,
  input  logic [WORD_W-1:0]  wrWord,
  input  logic [PIX_W-1:0]   ramData,
  input  logic [WORD_W-1:0]  rdWord,
  input  logic [PLN_W-1:0]   rdPlane,
  output logic [NUM_DRV-1:0] drvBits
);

  // One word per (row, LED) holds that pixel for every driver.
  logic [NUM_DRV-1:0][PIX_W-1:0] mem [2][WORDS];
  logic [NUM_DRV-1:0][PIX_W-1:0] rdVec;
  logic [BIT_W-1:0]              bitSel;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[ctl.wrBank][wrWord][wrDrv] <= ramData;
  end

  always_comb begin
    rdVec  = mem[ctl.rdBank][rdWord];
    bitSel = BIT_W'(PIX_W - 1) - BIT_W'(rdPlane);
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    assign drvBits[d] = rdVec[d][bitSel];
  end

endmodule

// File: rtl/slice_pingpong_buf.sv
module slice_pingpong_buf
  import spb_pkg::*;
#(
  parameter int NUM_DRV = 30,
  parameter int LEDS    = 16,
  parameter int MUX     = 8,
  parameter int PIX_W   = 16,
  parameter int PLANES  = 16,
  localparam int WORDS  = MUX * LEDS,
  localparam int ADDR_W = bitsFor(NUM_DRV * WORDS),
  localparam int ROW_W  = bitsFor(MUX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               posStrobe,
  input  logic               dataEn,
  input  logic [PIX_W-1:0]   ramData,
  output logic               ramRd,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic               drvValid,
  output logic [NUM_DRV-1:0] drvBits,
  output logic [ROW_W-1:0]   muxRow,
  output logic               newSlice,
  output logic               overrun
);

  localparam int WORD_W = bitsFor(WORDS);
  localparam int DRV_W  = bitsFor(NUM_DRV);
  localparam int PLN_W  = bitsFor(PLANES);

  spbStrobes_t       ctl;
  logic [DRV_W-1:0]  wrDrv;
  logic [WORD_W-1:0] wrWord, rdWord;
  logic [PLN_W-1:0]  rdPlane;

  spb_ctrl #(
    .NUM_DRV(NUM_DRV), .LEDS(LEDS), .MUX(MUX), .PIX_W(PIX_W), .PLANES(PLANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .posStrobe(posStrobe), .dataEn(dataEn),
    .ramRd(ramRd), .ramAddr(ramAddr), .ctl(ctl), .wrDrv(wrDrv), .wrWord(wrWord),
    .rdWord(rdWord), .rdPlane(rdPlane), .drvValid(drvValid), .muxRow(muxRow),
    .newSlice(newSlice), .overrun(overrun)
  );

  spb_datapath #(
    .NUM_DRV(NUM_DRV), .LEDS(LEDS), .MUX(MUX), .PIX_W(PIX_W), .PLANES(PLANES)
  ) u_dp (
    .clk(clk), .ctl(ctl), .wrDrv(wrDrv), .wrWord(wrWord), .ramData(ramData),
    .rdWord(rdWord), .rdPlane(rdPlane), .drvBits(drvBits)
  );

endmodule

// File: rtl/spb_checks.sv
module spb_checks
  import spb_pkg::*;
#(
  parameter int NUM_DRV = 30,
  parameter int LEDS    = 16,
  parameter int MUX     = 8,
  localparam int ADDR_W = bitsFor(NUM_DRV * MUX * LEDS),
  localparam int ROW_W  = bitsFor(MUX)
) (
  input logic               clk,
  input logic               rstN,
  input logic               dataEn,
  input logic               ramRd,
  input logic [ADDR_W-1:0]  ramAddr,
  input logic               drvValid,
  input logic [NUM_DRV-1:0] drvBits,
  input logic [ROW_W-1:0]   muxRow,
  input logic               newSlice,
  input logic               overrun
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    newSlice |=> !newSlice);

  a_r8_first_row: assert property (@(posedge clk) disable iff (!rstN)
    newSlice |-> (drvValid && muxRow == '0));

  a_r6_hold_on_pause: assert property (@(posedge clk) disable iff (!rstN)
    (drvValid && !dataEn) |=> (drvValid && $stable(drvBits) && $stable(muxRow)));

  a_r9_overrun_idle: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !drvValid);

  a_r2_addr_walk: assert property (@(posedge clk) disable iff (!rstN)
    (ramRd && $past(ramRd)) |-> (ramAddr == ADDR_W'($past(ramAddr) + 1'b1)));

  a_r2_fill_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramRd) |-> (ramAddr == '0));

endmodule

bind slice_pingpong_buf spb_checks #(
  .NUM_DRV(NUM_DRV), .LEDS(LEDS), .MUX(MUX)
) i_checks (
  .clk(clk), .rstN(rstN), .dataEn(dataEn), .ramRd(ramRd), .ramAddr(ramAddr),
  .drvValid(drvValid), .drvBits(drvBits), .muxRow(muxRow),
  .newSlice(newSlice), .overrun(overrun)
);

// File: tb/test_slice_pingpong_buf.sv
`timescale 1ns/1ps
module test_slice_pingpong_buf;

  localparam int ND = 3, NL = 4, NM = 2, PW = 5, NP = 3;
  localparam int NPIX = ND * NM * NL;
  localparam int AW = $clog2(NPIX);

  logic clk = 1'b0, rstN = 1'b0, posStrobe = 1'b0, dataEn = 1'b0;
  logic [PW-1:0] ramData = '0;
  logic ramRd, drvValid, newSlice, overrun;
  logic [AW-1:0] ramAddr;
  logic [ND-1:0] drvBits;
  logic muxRow;

  int checks = 0, failures = 0, fillNo = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slice_pingpong_buf #(.NUM_DRV(ND), .LEDS(NL), .MUX(NM), .PIX_W(PW), .PLANES(NP))
    i_slice_pingpong_buf (
      .clk(clk), .rstN(rstN), .posStrobe(posStrobe), .dataEn(dataEn),
      .ramData(ramData), .ramRd(ramRd), .ramAddr(ramAddr), .drvValid(drvValid),
      .drvBits(drvBits), .muxRow(muxRow), .newSlice(newSlice), .overrun(overrun));

  function automatic int pixVal(int s, int p);
    return (p * 7 + s * 13 + 5) % (1 << PW);
  endfunction

  // pixel memory model, one cycle latency
  always @(posedge clk) if (ramRd) ramData <= PW'(pixVal(fillNo, int'(ramAddr)));

  task automatic chkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expectAt(int s, int row, int plane, int led, string vreq);
    int expBits = 0;
    for (int d = 0; d < ND; d++) begin
      int pix = pixVal(s, (d * NM + row) * NL + led);  // R4 mapping
      expBits |= ((pix >> (PW - 1 - plane)) & 1) << d;
    end
    chkEq(vreq, int'(drvValid), 1);
    chkEq("R5 row", int'(muxRow), row);
    chkEq("R4 bits", int'(drvBits), expBits);
  endtask

  task automatic drainSlice(int s, bit stalls, int strobeFirst, bit strobeLast);
    int idx = 0;
    for (int row = 0; row < NM; row++)
      for (int plane = 0; plane < NP; plane++)
        for (int led = 0; led < NL; led++) begin
          bit last = (idx == NM * NP * NL - 1);
          if (stalls && idx != 0 && (idx % 3) == 1) begin
            dataEn = 1'b0;
            tick();
            expectAt(s, row, plane, led, "R6 hold");
          end
          expectAt(s, row, plane, led, idx == 0 ? "R7 swap" : "R5 valid");
          chkEq("R8 pulse", int'(newSlice), idx == 0 ? 1 : 0);
          if (idx == 0) chkEq("R9 clear", int'(overrun), 0);
          if (idx == 0 && strobeFirst >= 0) begin
            fillNo = strobeFirst;
            posStrobe = 1'b1;
          end
          if (last && strobeLast) posStrobe = 1'b1;
          dataEn = 1'b1;
          tick();
          dataEn = 1'b0;
          posStrobe = 1'b0;
          if (last && strobeLast) chkEq("R3 waiting", int'(ramRd), 0);
          idx++;
        end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    chkEq("R1 valid", int'(drvValid), 0);
    chkEq("R1 pulse", int'(newSlice), 0);
    chkEq("R1 overrun", int'(overrun), 0);
    chkEq("R1 rd", int'(ramRd), 0);
    rstN = 1'b1;
    tick();
    chkEq("R1 valid", int'(drvValid), 0);
    chkEq("R1 rd", int'(ramRd), 0);

    // first fill, with an extra strobe in the middle
    fillNo = 0;
    posStrobe = 1'b1;
    tick();
    posStrobe = 1'b0;
    for (int i = 0; i < NPIX; i++) begin
      chkEq("R2 rd", int'(ramRd), 1);
      chkEq("R2 addr", int'(ramAddr), i);  // R3: strobe at i=5 must not restart
      if (i == 5) posStrobe = 1'b1;
      tick();
      posStrobe = 1'b0;
    end
    chkEq("R2 end", int'(ramRd), 0);
    chkEq("R7 idle", int'(drvValid), 0);
    tick();
    chkEq("R7 idle", int'(drvValid), 0);
    tick();

    // slice 0 drained while slice 1 loads; seamless swaps
    drainSlice(0, 1'b1, 1, 1'b0);
    drainSlice(1, 1'b1, 2, 1'b1);
    // slice 2 drained with no refill: overrun
    drainSlice(2, 1'b0, -1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chkEq("R9 idle", int'(drvValid), 0);
      chkEq("R9 flag", int'(overrun), 1);
      chkEq("R9 rd", int'(ramRd), 0);
      tick();
    end
    fillNo = 3;
    posStrobe = 1'b1;
    tick();
    posStrobe = 1'b0;
    for (int k = 0; k < NPIX + 2; k++) begin
      chkEq("R9 idle", int'(drvValid), 0);
      chkEq("R9 flag", int'(overrun), 1);
      tick();
    end
    drainSlice(3, 1'b0, -1, 1'b0);
    chkEq("R9 flag", int'(overrun), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule